// File: doc/BRIEF.md
# DDR Write Data Capture with Truncation Masking

This block sits on the memory side of a double-data-rate write path. It runs on a sampling clock `clk` that is `OVS` times faster than the memory command clock. Commands, the data strobe `dqs`, the data lines `dq` and the per-byte mask `dm` are all taken as already synchronous to `clk`. After a Write command the block waits for the first rising strobe edge. That edge must fall inside a window of 0.75 to 1.25 command-clock periods. From that edge on, the block takes one data element on every strobe transition and bundles each rising/falling pair into one write on the array port. The write carries an address, double-width data and byte enables.

Committed pairs pass through a short aging pipeline before they reach the array port. A Read or Precharge command removes the pairs that completed too recently for the array to accept them. Read uses a short guard and Precharge uses a longer one. The same command also ends any burst that is still running. A first strobe edge that comes too early, or that has not come by the end of the window, sets a sticky timing-error flag, and that burst is thrown away.

Top module: `ddr_wcap`

## Requirements
- R1: While `rst_n` is low at a clock edge, `wr_en` and `timing_err` are 0 after that edge.
- R2: A Write (`cmd`=2'b01) takes its start column from `cmd_col`. The first strobe rise sampled 3, 4 or 5 edges after the edge that samples the Write (0.75 to 1.25 × `OVS`, with `OVS`=4) captures element 0. Each later strobe transition sampled by the block captures the next element. Each pair is written with the rising element in `wr_data[15:0]` and the falling element in `wr_data[31:16]`. A burst holds `BURST_LEN`=4 elements, which is 2 pairs.
- R3: A strobe rise sampled 1 or 2 edges after the Write, or no rise by the 5th edge, sets `timing_err`. Nothing from that burst is written. Only reset clears `timing_err`.
- R4: Pair p of a burst is written at {`cmd_col`[7:2], (`cmd_col`[1]+p) mod 2, 0}. Bit 0 of the start column is ignored, and the pair offset wraps at the burst boundary.
- R5: `wr_be` is the bitwise inverse of the two masks: bits [1:0] come from the rising element's `dm`, bits [3:2] from the falling element's `dm`. A set mask bit clears the enable of its byte.
- R6: A pair whose falling strobe is sampled at edge t appears with `wr_en`=1 for exactly one clock, after edge t+3. Two commits are never in adjacent cycles.
- R7: Read (`cmd`=2'b10) sampled at edge t drops every pair whose falling strobe was sampled at an edge in [t-1, t]. It also ends the burst, so later strobe edges are not captured.
- R8: Precharge (`cmd`=2'b11) sampled at edge t drops every pair whose falling strobe was sampled at an edge in [t-3, t]. It also ends the burst.
- R9: Strobe transitions after a burst completes do not cause writes. A Write sampled while a burst is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, `OVS` ticks per command-clock period |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd | input | 2 | Command: 00 none, 01 write, 10 read, 11 precharge |
| cmd_col | input | COL_W | Start column, taken with a Write |
| dqs | input | 1 | Data strobe, already sampled into the `clk` domain |
| dq | input | DQ_W | Write data element |
| dm | input | DQ_W/8 | Per-byte mask of the element, 1 = do not write |
| wr_en | output | 1 | Array write strobe for one pair |
| wr_addr | output | COL_W | Column of the pair's first element |
| wr_data | output | 2*DQ_W | Pair data, first element in the low half |
| wr_be | output | 2*DQ_W/8 | Byte enables of the pair |
| timing_err | output | 1 | Sticky flag for a first strobe edge outside the window |

## Verification
A pair completes on a falling strobe edge, and that edge can coincide with a Read or Precharge command; the command must win and drop the pair. The bench slides the interrupt across every edge offset from before the first strobe rise to well past the last pair, for both command types and for every first-edge delay from 1 to 7 ticks. For each combination it computes arithmetically which pairs survive, what they contain and on which tick each one appears. The same sweep also makes an interrupt land on the very edge where a window violation would be flagged, and there the error must not be set.

// File: rtl/ddr_wcap_pkg.sv
// Shared encodings for the write-capture block.
package ddr_wcap_pkg;
    // Command code seen on cmd; only these four values exist.
    typedef enum logic [1:0] {
        CMD_NOP   = 2'b00,
        CMD_WRITE = 2'b01,
        CMD_READ  = 2'b10,
        CMD_PRE   = 2'b11
    } cmd_e;

    // Burst sequencing state.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'b00,
        ST_WAIT  = 2'b01,
        ST_BURST = 2'b10
    } cap_st_e;
endpackage

// File: rtl/ddr_wcap_ctrl.sv
// Burst sequencer: opens the first-edge window after a Write, counts
// elements and pairs, forms the pair column and flags window violations.
// Assumes strobe edges are already detected in the clk domain and that
// BURST_LEN >= 4 and COL_W > log2(BURST_LEN).
module ddr_wcap_ctrl
    import ddr_wcap_pkg::*;
#(
    parameter int OVS       = 4,
    parameter int BURST_LEN = 4,
    parameter int COL_W     = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       cmd,
    input  logic [COL_W-1:0] cmd_col,
    input  logic             strobe_rise,
    input  logic             strobe_fall,
    output logic             take_first,
    output logic             take_pair,
    output logic [COL_W-1:0] pair_addr,
    output logic             timing_err
);
    localparam int WIN_LO = (3 * OVS) / 4;
    localparam int WIN_HI = (5 * OVS) / 4;
    localparam int CNT_W  = $clog2(WIN_HI + 1);
    localparam int LBL    = $clog2(BURST_LEN);
    localparam int PW     = LBL - 1;
    localparam int NP     = BURST_LEN / 2;

    cap_st_e          st;
    logic [CNT_W-1:0] wait_cnt;
    logic [PW-1:0]    pidx;
    logic             half;
    logic [COL_W-1:0] base;
    logic             is_wr, is_stop, in_win, err_set, last_pair;
    logic [LBL-1:0]   off;

    // Decode the command and the window position.
    always_comb begin
        is_wr     = (cmd == CMD_WRITE);
        is_stop   = (cmd == CMD_READ) || (cmd == CMD_PRE);
        in_win    = (wait_cnt >= CNT_W'(WIN_LO));
        last_pair = (pidx == PW'(NP - 1));
    end

    // Capture strobes; an interrupting command overrides any edge.
    always_comb begin
        take_first = !is_stop && strobe_rise &&
                     ((st == ST_WAIT && in_win) || (st == ST_BURST && !half));
        take_pair  = !is_stop && strobe_fall && (st == ST_BURST) && half;
        err_set    = !is_stop && (st == ST_WAIT) &&
                     ((strobe_rise && !in_win) ||
                      (!strobe_rise && wait_cnt == CNT_W'(WIN_HI)));
    end

    // Pair column: upper bits kept, pair offset wraps inside the burst.
    always_comb begin
        off       = {base[LBL-1:1] + pidx, 1'b0};
        pair_addr = {base[COL_W-1:LBL], off};
    end

    // Sequencer state, counters and sticky error flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st         <= ST_IDLE;
            wait_cnt   <= '0;
            pidx       <= '0;
            half       <= 1'b0;
            base       <= '0;
            timing_err <= 1'b0;
        end else begin
            if (err_set) timing_err <= 1'b1;
            if (is_stop) begin
                st <= ST_IDLE;
            end else begin
                case (st)
                    ST_IDLE: if (is_wr) begin
                        st       <= ST_WAIT;
                        wait_cnt <= CNT_W'(1);
                        base     <= cmd_col;
                    end
                    ST_WAIT: begin
                        if (take_first) begin
                            st   <= ST_BURST;
                            half <= 1'b1;
                            pidx <= '0;
                        end else if (err_set) begin
                            st <= ST_IDLE;
                        end else begin
                            wait_cnt <= wait_cnt + CNT_W'(1);
                        end
                    end
                    ST_BURST: begin
                        if (take_first) begin
                            half <= 1'b1;
                        end else if (take_pair) begin
                            half <= 1'b0;
                            if (last_pair) st <= ST_IDLE;
                            else           pidx <= pidx + PW'(1);
                        end
                    end
                    default: st <= ST_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/ddr_wcap_pair.sv
// Pair assembler: detects strobe transitions, holds the rising-edge
// element, and presents the complete pair on the falling edge.
// Assumes dqs/dq/dm are synchronous to clk (no metastability handling).
module ddr_wcap_pair #(
    parameter int DQ_W   = 16,
    parameter int MASK_W = DQ_W / 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                dqs,
    input  logic [DQ_W-1:0]     dq,
    input  logic [MASK_W-1:0]   dm,
    input  logic                take_first,
    output logic                strobe_rise,
    output logic                strobe_fall,
    output logic [2*DQ_W-1:0]   pair_data,
    output logic [2*MASK_W-1:0] pair_be
);
    logic              dqs_q;
    logic [DQ_W-1:0]   first_d;
    logic [MASK_W-1:0] first_m;

    // Edge detection against the previous strobe sample.
    always_comb begin
        strobe_rise = dqs && !dqs_q;
        strobe_fall = !dqs && dqs_q;
        pair_data   = {dq, first_d};
        pair_be     = ~{dm, first_m};
    end

    // Previous strobe level and the held rising-edge element.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dqs_q   <= 1'b0;
            first_d <= '0;
            first_m <= '0;
        end else begin
            dqs_q <= dqs;
            if (take_first) begin
                first_d <= dq;
                first_m <= dm;
            end
        end
    end
endmodule

// File: rtl/ddr_wcap_commit.sv
// Commit aging pipeline: each completed pair ages DEPTH stages before it
// reaches the array port. A Read kills stages younger than RD_GUARD and a
// Precharge kills stages younger than PRE_GUARD. Assumes
// DEPTH >= max(RD_GUARD, PRE_GUARD) and both guards >= 1.
module ddr_wcap_commit #(
    parameter int AW        = 8,
    parameter int DW2       = 32,
    parameter int BW2       = 4,
    parameter int DEPTH     = 4,
    parameter int RD_GUARD  = 2,
    parameter int PRE_GUARD = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           in_vld,
    input  logic [AW-1:0]  in_addr,
    input  logic [DW2-1:0] in_data,
    input  logic [BW2-1:0] in_be,
    input  logic           kill_rd,
    input  logic           kill_pre,
    output logic           wr_en,
    output logic [AW-1:0]  wr_addr,
    output logic [DW2-1:0] wr_data,
    output logic [BW2-1:0] wr_be
);
    for (genvar m = 0; m < DEPTH; m++) begin : g_stage
        localparam bit RD_HIT  = (m < RD_GUARD);
        localparam bit PRE_HIT = (m < PRE_GUARD);
        logic           v, src_v, kill;
        logic [AW-1:0]  a, src_a;
        logic [DW2-1:0] d, src_d;
        logic [BW2-1:0] b, src_b;

        // Stage m's entry would be m edges old after a kill at this edge.
        assign kill = (RD_HIT && kill_rd) || (PRE_HIT && kill_pre);

        if (m == 0) begin : g_head
            assign src_v = in_vld;
            assign src_a = in_addr;
            assign src_d = in_data;
            assign src_b = in_be;
        end else begin : g_tail
            assign src_v = g_stage[m-1].v;
            assign src_a = g_stage[m-1].a;
            assign src_d = g_stage[m-1].d;
            assign src_b = g_stage[m-1].b;
        end

        // Valid bit of the stage, cleared by reset or by a kill.
        always_ff @(posedge clk) begin
            if (!rst_n) v <= 1'b0;
            else        v <= src_v && !kill;
        end

        // Payload moves along with the valid bit.
        always_ff @(posedge clk) begin
            a <= src_a;
            d <= src_d;
            b <= src_b;
        end
    end

    assign wr_en   = g_stage[DEPTH-1].v;
    assign wr_addr = g_stage[DEPTH-1].a;
    assign wr_data = g_stage[DEPTH-1].d;
    assign wr_be   = g_stage[DEPTH-1].b;
endmodule

// File: rtl/ddr_wcap.sv
// Top level of the DDR write-capture block: strobe-edge pair assembly,
// burst sequencing with first-edge window check, and a commit pipeline
// that drops late pairs when a Read or Precharge truncates the burst.
// Assumes all inputs are synchronous to the OVS-times sampling clock.
module ddr_wcap
    import ddr_wcap_pkg::*;
#(
    parameter int OVS       = 4,
    parameter int DQ_W      = 16,
    parameter int COL_W     = 8,
    parameter int BURST_LEN = 4,
    parameter int RD_GUARD  = 2,
    parameter int PRE_GUARD = 4,
    localparam int MASK_W   = DQ_W / 8,
    localparam int PIPE_D   = (RD_GUARD > PRE_GUARD) ? RD_GUARD : PRE_GUARD
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          cmd,
    input  logic [COL_W-1:0]    cmd_col,
    input  logic                dqs,
    input  logic [DQ_W-1:0]     dq,
    input  logic [MASK_W-1:0]   dm,
    output logic                wr_en,
    output logic [COL_W-1:0]    wr_addr,
    output logic [2*DQ_W-1:0]   wr_data,
    output logic [2*MASK_W-1:0] wr_be,
    output logic                timing_err
);
    logic                strobe_rise, strobe_fall, take_first, take_pair;
    logic                kill_rd, kill_pre;
    logic [COL_W-1:0]    pair_addr;
    logic [2*DQ_W-1:0]   pair_data;
    logic [2*MASK_W-1:0] pair_be;

    // Interrupt decode feeding the commit pipeline.
    assign kill_rd  = (cmd == CMD_READ);
    assign kill_pre = (cmd == CMD_PRE);

    ddr_wcap_pair #(.DQ_W(DQ_W), .MASK_W(MASK_W)) u_pair (
        .clk(clk), .rst_n(rst_n), .dqs(dqs), .dq(dq), .dm(dm),
        .take_first(take_first), .strobe_rise(strobe_rise),
        .strobe_fall(strobe_fall), .pair_data(pair_data), .pair_be(pair_be)
    );

    ddr_wcap_ctrl #(.OVS(OVS), .BURST_LEN(BURST_LEN), .COL_W(COL_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .cmd(cmd), .cmd_col(cmd_col),
        .strobe_rise(strobe_rise), .strobe_fall(strobe_fall),
        .take_first(take_first), .take_pair(take_pair),
        .pair_addr(pair_addr), .timing_err(timing_err)
    );

    ddr_wcap_commit #(
        .AW(COL_W), .DW2(2*DQ_W), .BW2(2*MASK_W), .DEPTH(PIPE_D),
        .RD_GUARD(RD_GUARD), .PRE_GUARD(PRE_GUARD)
    ) u_commit (
        .clk(clk), .rst_n(rst_n), .in_vld(take_pair), .in_addr(pair_addr),
        .in_data(pair_data), .in_be(pair_be), .kill_rd(kill_rd),
        .kill_pre(kill_pre), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_be(wr_be)
    );
endmodule

// File: rtl/ddr_wcap_chk.sv
// Property checker for ddr_wcap, attached by bind. Tracks, per interrupt
// type, the output cycles that must stay free of commits.
module ddr_wcap_chk
    import ddr_wcap_pkg::*;
#(
    parameter int PIPE_D    = 4,
    parameter int RD_GUARD  = 2,
    parameter int PRE_GUARD = 4
) (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] cmd,
    input logic       wr_en,
    input logic       addr_lsb,
    input logic       timing_err
);
    localparam logic [PIPE_D-1:0] QM_RD  = ~({PIPE_D{1'b1}} >> RD_GUARD);
    localparam logic [PIPE_D-1:0] QM_PRE = ~({PIPE_D{1'b1}} >> PRE_GUARD);

    logic [PIPE_D-1:0] q_rd, q_pre;

    // Bit i marks the (i+1)-th coming edge as one with no commit allowed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_rd  <= '0;
            q_pre <= '0;
        end else begin
            q_rd  <= (q_rd  >> 1) | ((cmd == CMD_READ) ? QM_RD  : '0);
            q_pre <= (q_pre >> 1) | ((cmd == CMD_PRE)  ? QM_PRE : '0);
        end
    end

    assert_err_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        timing_err |=> timing_err);

    assert_pair_align_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !addr_lsb);

    assert_commit_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en);

    assert_rd_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        q_rd[0] |-> !wr_en);

    assert_pre_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        q_pre[0] |-> !wr_en);
endmodule

bind ddr_wcap ddr_wcap_chk #(
    .PIPE_D(PIPE_D), .RD_GUARD(RD_GUARD), .PRE_GUARD(PRE_GUARD)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .wr_en(wr_en),
    .addr_lsb(wr_addr[0]), .timing_err(timing_err)
);

// File: tb/test_ddr_wcap.sv
`timescale 1ns/1ps
module test_ddr_wcap;
    localparam int BL = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cmd = 2'b00;
    logic [7:0]  cmd_col = 8'h00;
    logic        dqs = 1'b0;
    logic [15:0] dq = 16'h0000;
    logic [1:0]  dm = 2'b00;
    logic        wr_en, timing_err;
    logic [7:0]  wr_addr;
    logic [31:0] wr_data;
    logic [3:0]  wr_be;

    int vectors = 0, miscompares = 0, tick = 0, scn = 0;
    bit done = 0;
    logic [7:0]  got_a [8];
    logic [31:0] got_d [8];
    logic [3:0]  got_b [8];
    int          got_t [8];
    int          got_n = 0;

    ddr_wcap i_ddr_wcap (
        .clk(clk), .rst_n(rst_n), .cmd(cmd), .cmd_col(cmd_col), .dqs(dqs),
        .dq(dq), .dm(dm), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_be(wr_be), .timing_err(timing_err)
    );

    always #10 clk = ~clk;
    always @(posedge clk) tick <= tick + 1;

    // Record every commit, sampled away from the active edge.
    always @(negedge clk) begin
        if (rst_n === 1'b1 && wr_en === 1'b1) begin
            if (got_n < 8) begin
                got_a[got_n] = wr_addr;
                got_d[got_n] = wr_data;
                got_b[got_n] = wr_be;
                got_t[got_n] = tick;
            end
            got_n = got_n + 1;
        end
    end

    function automatic logic [15:0] e_val(int s, int e);
        return 16'(s * 37 + e * 4099 + 1);
    endfunction

    function automatic logic [1:0] m_val(int s, int e);
        return 2'((s + e) % 4);
    endfunction

    task automatic check(input bit ok, input string tag,
                         input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s scenario %0d: actual %0h expected %0h", tag, scn, act, exp);
        end
    endtask

    task automatic reset_dut();
        @(negedge clk);
        rst_n = 1'b0; cmd = 2'b00; dqs = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // One write burst; itype 0 none, 1 read, 2 precharge at edge offset ki.
    task automatic run_scn(input int d, input logic [7:0] col, input int itype,
                           input int ki, input bit wr2, input bit extra,
                           input bit do_rst, input bit prior_err);
        int t0 = 0, exp_n = 0, det, win, tc;
        bit bad, exp_err, keep, pb;
        logic [7:0]  ea [2];
        logic [31:0] ed [2];
        logic [3:0]  eb [2];
        int          et [2];
        string       ctag;
        if (do_rst) reset_dut();
        scn++;
        got_n = 0;
        for (int k = 0; k < 24; k++) begin
            @(negedge clk);
            if (k == 0) t0 = tick + 1;
            cmd = 2'b00; cmd_col = 8'h00;
            if (k == 0) begin
                cmd = 2'b01; cmd_col = col;
            end else if (itype != 0 && k == ki) begin
                cmd = (itype == 1) ? 2'b10 : 2'b11;
            end else if (wr2 && k == d + 3) begin
                cmd = 2'b01; cmd_col = col ^ 8'h5A;
            end
            if (k >= d && k < d + 2 * BL) begin
                dqs = (((k - d) / 2) % 2) == 0;
                dq  = e_val(scn, (k - d) / 2);
                dm  = m_val(scn, (k - d) / 2);
            end else begin
                dqs = extra && (k == d + 9 || k == d + 10 || k == d + 13);
                dq  = 16'hDEAD ^ 16'(k);
                dm  = 2'b00;
            end
        end
        @(negedge clk);
        cmd = 2'b00; dqs = 1'b0;
        repeat (2) @(negedge clk);

        bad     = (d < 3) || (d > 5);
        det     = (d < 3) ? d : 5;
        win     = (itype == 1) ? 2 : 4;
        exp_err = prior_err || (bad && !(itype != 0 && ki <= det));
        if (!bad) begin
            for (int p = 0; p < 2; p++) begin
                tc   = d + 4 * p + 2;
                keep = (itype == 0) || (tc < ki && ki - tc >= win);
                if (keep) begin
                    pb = col[1] ^ (p == 1);
                    ea[exp_n] = {col[7:2], pb, 1'b0};
                    ed[exp_n] = {e_val(scn, 2 * p + 1), e_val(scn, 2 * p)};
                    eb[exp_n] = ~{m_val(scn, 2 * p + 1), m_val(scn, 2 * p)};
                    et[exp_n] = t0 + tc + 3;
                    exp_n++;
                end
            end
        end
        ctag = (itype == 1) ? "R7 commit count" : (itype == 2) ? "R8 commit count" :
               (wr2 || extra) ? "R9 commit count" : "R2 commit count";
        check(got_n == exp_n, ctag, 64'(got_n), 64'(exp_n));
        check(timing_err == exp_err, "R3 timing_err", 64'(timing_err), 64'(exp_err));
        for (int i = 0; i < exp_n && i < got_n; i++) begin
            check(got_a[i] == ea[i], "R4 address", 64'(got_a[i]), 64'(ea[i]));
            check(got_d[i] == ed[i], "R2 pair data", 64'(got_d[i]), 64'(ed[i]));
            check(got_b[i] == eb[i], "R5 byte enables", 64'(got_b[i]), 64'(eb[i]));
            check(got_t[i] == et[i], "R6 commit tick", 64'(got_t[i]), 64'(et[i]));
        end
    endtask

    initial begin
        logic [7:0] cols [2];
        cols[0] = 8'h00;
        cols[1] = 8'hA7;
        reset_dut();
        @(negedge clk);
        check(wr_en == 1'b0, "R1 wr_en after reset", 64'(wr_en), 64'd0);
        check(timing_err == 1'b0, "R1 timing_err after reset", 64'(timing_err), 64'd0);

        for (int d = 1; d <= 7; d++) begin
            for (int c = 0; c < 2; c++) begin
                run_scn(d, cols[c], 0, 0, (d >= 3 && d <= 5 && d % 2 == 1),
                        (c == 1), 1'b1, 1'b0);
                for (int it = 1; it <= 2; it++) begin
                    for (int ki = 1; ki <= 14; ki++) begin
                        run_scn(d, cols[c], it, ki, 1'b0, (ki % 3 == 0), 1'b1, 1'b0);
                    end
                end
            end
        end

        // R3: the flag survives a later good burst and only reset clears it.
        run_scn(1, 8'h10, 0, 0, 1'b0, 1'b0, 1'b1, 1'b0);
        run_scn(4, 8'h3C, 0, 0, 1'b0, 1'b0, 1'b0, 1'b1);
        reset_dut();
        @(negedge clk);
        check(timing_err == 1'b0, "R3 cleared by reset", 64'(timing_err), 64'd0);
        check(wr_en == 1'b0, "R1 wr_en idle after reset", 64'(wr_en), 64'd0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            vectors++;
            miscompares++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule